// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM has one active-low enable, one active-high enable, an active-low output enable and an active-low write enable. The host hands over one word-sized read or write at a time with a valid/ready handshake. The controller then plays out the strobe sequence on the memory pins. It holds each phase for a whole number of clock cycles, so that every minimum cycle time, pulse width, setup and hold time of the memory is met.

Every nanosecond figure is turned into a cycle count by rounding up against the clock period, which is a parameter. A second parameter selects the 55 ns or the 70 ns speed grade. The data bus comes out as three signals: an output value, an output-enable and an input value. The pad tri-state buffer is placed outside the block. The controller turns its drivers on only while the write strobe is low. It never turns them on until the memory has had time to release the bus after a read.

Read data is latched on the final cycle of the read strobe. The host sees it with a single-cycle valid pulse.

Top module: `sram_timing_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is free, the pins are idle: `sram_ce1_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `rd_valid`=0, and `req_ready`=1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high, with `req_write`=1 meaning write and 0 meaning read. `req_ready` is low from the next cycle until the whole sequence is over. A request held high while the controller is busy is not taken early.
- R3: A read starts on the edge after acceptance. For N_RD = max(ceil(tCYC/T), ceil(tOEA/T)) cycles it drives `sram_ce1_n`=0, `sram_ce2`=1, `sram_oe_n`=0 and `sram_we_n`=1. T is `CLK_NS`.
- R4: The input bus is sampled at the edge that ends the last read cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle, which is the cycle after the strobes release.
- R5: After a read there are N_TA = ceil(tREL/T) cycles with all strobes released and `req_ready` low. `sram_dq_oe` never rises fewer than N_TA cycles after `sram_oe_n` went high.
- R6: A write holds both enables active, `sram_we_n`=0 and `sram_oe_n`=1 for N_WE = max(ceil(tWP/T), ceil(tASU/T), ceil(tDSU/T)) cycles. `sram_dq_oe` is high with the write data on `sram_dq_o` for exactly those cycles, and it drops on the edge where `sram_we_n` rises.
- R7: After a write there are max(ceil(tCYC/T) - N_WE, 0) recovery cycles with the strobes released and `req_ready` low.
- R8: With `GRADE_NS` at 55 or below, the figures are tCYC=55, tOEA=25, tWP=40, tASU=40, tDSU=25 and tREL=20 ns. Any other value gives 70, 35, 50, 60, 30 and 25 ns.
- R9: `sram_addr` takes the request address at acceptance and holds it unchanged while any strobe is active.
- R10: Against a memory model that enforces the R8 figures in nanoseconds, data written to an address is read back unchanged. Unwritten locations read as zero in that model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Data for a write |
| req_ready | output | 1 | Controller free to take a request |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a fresh read word |
| rd_data | output | DATA_W | Captured read word |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_o | output | DATA_W | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Enable of the data bus drivers |
| sram_dq_i | input | DATA_W | Value seen on the data bus |

## Verification
The bench builds two copies side by side on a 10 ns clock, one with `GRADE_NS`=55 and one with 70. This gives read/write/recovery/turnaround counts of 6/4/2/2 and 7/6/1/3 cycles. The 70 ns copy makes the read capture land exactly on the access time, so a read that is one cycle short returns garbage. It also makes the address-setup figure, not the pulse width, decide the write length. The stub memory measures every strobe in nanoseconds, separately from the cycle arithmetic.

// File: rtl/sram_tc_pkg.sv
`timescale 1ns/1ps
package sram_tc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WREC,
    ST_TURN
  } st_e;

  typedef enum logic [2:0] {
    K_CYCLE,
    K_OE_ACC,
    K_WE_PULSE,
    K_ADDR_SU,
    K_DATA_SU,
    K_RELEASE
  } tim_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // nanosecond figure per speed grade
  function automatic int grade_ns(int grade, tim_e k);
    bit slow;
    slow = (grade > 55);
    case (k)
      K_CYCLE:    return slow ? 70 : 55;
      K_OE_ACC:   return slow ? 35 : 25;
      K_WE_PULSE: return slow ? 50 : 40;
      K_ADDR_SU:  return slow ? 60 : 40;
      K_DATA_SU:  return slow ? 30 : 25;
      K_RELEASE:  return slow ? 25 : 20;
      default:    return 70;
    endcase
  endfunction

  function automatic int ceil_cycles(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int n_read(int grade, int clk_ns);
    return imax(ceil_cycles(grade_ns(grade, K_CYCLE), clk_ns),
                ceil_cycles(grade_ns(grade, K_OE_ACC), clk_ns));
  endfunction

  function automatic int n_wpulse(int grade, int clk_ns);
    return imax(ceil_cycles(grade_ns(grade, K_WE_PULSE), clk_ns),
                imax(ceil_cycles(grade_ns(grade, K_ADDR_SU), clk_ns),
                     ceil_cycles(grade_ns(grade, K_DATA_SU), clk_ns)));
  endfunction

  function automatic int n_wrec(int grade, int clk_ns);
    return imax(ceil_cycles(grade_ns(grade, K_CYCLE), clk_ns) - n_wpulse(grade, clk_ns), 0);
  endfunction

  function automatic int n_turn(int grade, int clk_ns);
    return imax(ceil_cycles(grade_ns(grade, K_RELEASE), clk_ns), 1);
  endfunction

endpackage

// File: rtl/sram_tc_timer.sv
`timescale 1ns/1ps
module sram_tc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_tc_dbus.sv
`timescale 1ns/1ps
module sram_tc_dbus #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  assign dq_o  = wdata;
  assign dq_oe = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_i;
    end
  end

endmodule

// File: rtl/sram_timing_ctrl.sv
`timescale 1ns/1ps
module sram_timing_ctrl
  import sram_tc_pkg::*;
#(
  parameter int GRADE_NS = 55,
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int N_RD   = n_read(GRADE_NS, CLK_NS);
  localparam int N_WE   = n_wpulse(GRADE_NS, CLK_NS);
  localparam int N_WREC = n_wrec(GRADE_NS, CLK_NS);
  localparam int N_TA   = n_turn(GRADE_NS, CLK_NS);
  localparam int N_MAX  = imax(imax(N_RD, N_WE), imax(N_WREC, N_TA));
  localparam int CNT_W  = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  localparam logic [CNT_W-1:0] L_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] L_WE   = CNT_W'(N_WE - 1);
  localparam logic [CNT_W-1:0] L_TA   = CNT_W'(N_TA - 1);
  localparam logic [CNT_W-1:0] L_WREC = CNT_W'((N_WREC > 0) ? N_WREC - 1 : 0);

  st_e              st_q, st_d;
  logic             t_load, t_expired;
  logic [CNT_W-1:0] t_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // named events for the checker
  logic accept, cap_en, write_end;
  assign accept    = req_valid && (st_q == ST_IDLE);
  assign cap_en    = (st_q == ST_READ)  && t_expired;
  assign write_end = (st_q == ST_WRITE) && t_expired;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = req_write ? ST_WRITE : ST_READ;
        t_load = 1'b1;
        t_val  = req_write ? L_WE : L_RD;
      end
      ST_READ: if (t_expired) begin
        st_d   = ST_TURN;
        t_load = 1'b1;
        t_val  = L_TA;
      end
      ST_WRITE: if (t_expired) begin
        if (N_WREC > 0) begin
          st_d   = ST_WREC;
          t_load = 1'b1;
          t_val  = L_WREC;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WREC, ST_TURN: if (t_expired) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_tc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  logic strobe_on;
  assign strobe_on  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign sram_ce1_n = !strobe_on;
  assign sram_ce2   = strobe_on;
  assign sram_oe_n  = (st_q != ST_READ);
  assign sram_we_n  = (st_q != ST_WRITE);
  assign sram_addr  = addr_q;
  assign req_ready  = (st_q == ST_IDLE);

  sram_tc_dbus #(.DATA_W(DATA_W)) u_dbus (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive    (st_q == ST_WRITE),
    .wdata    (wdata_q),
    .capture  (cap_en),
    .dq_i     (sram_dq_i),
    .dq_o     (sram_dq_o),
    .dq_oe    (sram_dq_oe),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sram_tc_checker.sv
`timescale 1ns/1ps
module sram_tc_checker
  import sram_tc_pkg::*;
#(
  parameter int GRADE_NS = 55,
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic              accept,
  input logic              cap_en,
  input logic              write_end
);

  localparam int N_WE = n_wpulse(GRADE_NS, CLK_NS);
  localparam int N_TA = n_turn(GRADE_NS, CLK_NS);

  int we_low_cnt;
  int oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= 0;
      oe_hi_cnt  <= N_TA;
    end else begin
      we_low_cnt <= sram_we_n ? 0 : we_low_cnt + 1;
      if (!sram_oe_n)          oe_hi_cnt <= 0;
      else if (oe_hi_cnt < N_TA) oe_hi_cnt <= oe_hi_cnt + 1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_we_high_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);

  p_valid_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> rd_valid);

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_bus_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_cnt >= N_TA));

  p_we_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    write_end |-> (we_low_cnt == N_WE - 1));

  p_drive_under_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

endmodule

bind sram_timing_ctrl sram_tc_checker #(
  .GRADE_NS (GRADE_NS),
  .CLK_NS   (CLK_NS),
  .ADDR_W   (ADDR_W)
) u_sram_tc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_ce1_n (sram_ce1_n),
  .sram_ce2   (sram_ce2),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe),
  .accept     (accept),
  .cap_en     (cap_en),
  .write_end  (write_end)
);

// File: tb/sram_tc_harness.sv
`timescale 1ns/1ps
module sram_tc_harness #(
  parameter int GRADE_NS = 55,
  parameter int CLK_NS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_cmp,
  output int   n_bad,
  output logic done
);

  localparam int AW   = 17;
  localparam int DW   = 8;
  localparam int HALF = CLK_NS / 2;

  // R8 figures, restated on the bench side
  localparam int T_CYC = (GRADE_NS <= 55) ? 55 : 70;
  localparam int T_OEA = (GRADE_NS <= 55) ? 25 : 35;
  localparam int T_WP  = (GRADE_NS <= 55) ? 40 : 50;
  localparam int T_ASU = (GRADE_NS <= 55) ? 40 : 60;
  localparam int T_DSU = (GRADE_NS <= 55) ? 25 : 30;
  localparam int T_REL = (GRADE_NS <= 55) ? 20 : 25;

  function automatic int span(int ns);
    int n = 0;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp,
                     inout int c, inout int b);
    c++;
    if (!ok) begin
      b++;
      $display("FAIL %s grade %0d at %0t: got %0h expected %0h", tag, GRADE_NS, $time, act, exp);
    end
  endtask

  logic          req_valid, req_write, req_ready, rd_valid;
  logic [AW-1:0] req_addr, sram_addr;
  logic [DW-1:0] req_wdata, rd_data, dq_o, dq_i;
  logic          ce1_n, ce2, oe_n, we_n, dq_oe;

  sram_timing_ctrl #(.GRADE_NS(GRADE_NS), .CLK_NS(CLK_NS), .ADDR_W(AW), .DATA_W(DW)) i_sram_timing_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
  );

  int e_rd, e_we, e_wrec, e_ta;
  int s_cmp, s_bad, m_cmp, m_bad, x_cmp, x_bad;
  bit live;

  assign n_cmp = s_cmp + m_cmp + x_cmp;
  assign n_bad = s_bad + m_bad + x_bad;

  // ---------------- behavioural memory with ns timing checks (R8, R10)
  logic [DW-1:0] mem [int];
  longint t_addr, t_sel, t_oe_on, t_oe_off, t_wr_on, t_dq;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq;
  bit p_sel, p_wr, p_rd, p_dq_oe, last_wr, seen_sel;

  initial begin
    t_addr = 0; t_sel = 0; t_oe_on = 0; t_oe_off = -1000; t_wr_on = 0; t_dq = 0;
    p_addr = '0; p_dq = '0; p_sel = 0; p_wr = 0; p_rd = 0; p_dq_oe = 0;
    last_wr = 0; seen_sel = 0; x_cmp = 0; x_bad = 0; dq_i = 8'hEE;
  end

  always @(negedge clk) begin
    longint edge_t, nxt;
    bit sel, wr, rd, ok_rd;
    edge_t = $time - HALF;
    nxt    = $time + HALF;
    sel = !ce1_n && ce2;
    wr  = sel && !we_n;
    rd  = sel && !oe_n;
    if (p_wr && !wr) begin
      chk(edge_t - t_wr_on >= T_WP, "R8 WE pulse ns", edge_t - t_wr_on, T_WP, x_cmp, x_bad);
      chk(edge_t - t_addr >= T_ASU, "R8 address setup ns", edge_t - t_addr, T_ASU, x_cmp, x_bad);
      chk(p_dq_oe && (edge_t - t_dq >= T_DSU), "R8 data setup ns", edge_t - t_dq, T_DSU, x_cmp, x_bad);
      mem[int'(p_addr)] = p_dq;
    end
    if (sram_addr != p_addr) t_addr = edge_t;
    if (sel && !p_sel) begin
      if (seen_sel)
        chk(edge_t - t_sel >= T_CYC, "R8 cycle spacing ns", edge_t - t_sel, T_CYC, x_cmp, x_bad);
      seen_sel = 1;
      t_sel    = edge_t;
      last_wr  = wr;
    end
    if (rd && !p_rd) t_oe_on = edge_t;
    if (!rd && p_rd) t_oe_off = edge_t;
    if (wr && !p_wr) t_wr_on = edge_t;
    if (dq_oe && (!p_dq_oe || dq_o != p_dq)) t_dq = edge_t;
    if (dq_oe && !p_dq_oe)
      chk(!rd && (edge_t - t_oe_off >= T_REL), "R5 bus release ns", edge_t - t_oe_off, T_REL, x_cmp, x_bad);
    if (rd) chk(we_n, "R3 WE high in read", we_n, 1, x_cmp, x_bad);
    ok_rd = rd && (nxt - t_oe_on >= T_OEA) && (nxt - t_sel >= T_CYC) && (nxt - t_addr >= T_CYC);
    dq_i <= ok_rd ? (mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00) : 8'hEE;
    p_sel = sel; p_wr = wr; p_rd = rd; p_dq_oe = dq_oe; p_addr = sram_addr; p_dq = dq_o;
  end

  // ---------------- cycle reference: queue of expected pin vectors
  // bits: {ready, ce1 active, ce2 active, oe active, we active, drive, rvalid}
  logic [6:0] q [$];
  logic [DW-1:0] shadow [int];
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata, x_rdata;

  function automatic string tag_of(logic [6:0] e);
    if (e[0])      return "R4";
    if (e[3])      return "R3";
    if (e[2])      return "R6";
    if (e[6])      return "R1";
    return "R5 R7 R2";
  endfunction

  initial begin m_cmp = 0; m_bad = 0; end

  always @(negedge clk) if (live) begin
    logic [6:0] exp, act;
    exp = (q.size() != 0) ? q.pop_front() : 7'b1000000;
    act = {req_ready, !ce1_n, ce2, !oe_n, !we_n, dq_oe, rd_valid};
    chk(act == exp, tag_of(exp), act, exp, m_cmp, m_bad);
    if (exp[5]) chk(sram_addr == x_addr, "R9 address", sram_addr, x_addr, m_cmp, m_bad);
    if (exp[1]) chk(dq_o == x_wdata, "R6 write data", dq_o, x_wdata, m_cmp, m_bad);
    if (exp[0]) chk(rd_data == x_rdata, "R10 read data", rd_data, x_rdata, m_cmp, m_bad);
    if (req_valid && req_ready) begin
      x_addr = req_addr;
      if (req_write) begin
        x_wdata = req_wdata;
        shadow[int'(req_addr)] = req_wdata;
        repeat (e_we)   q.push_back(7'b0110110);
        repeat (e_wrec) q.push_back(7'b0000000);
      end else begin
        x_rdata = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00;
        repeat (e_rd) q.push_back(7'b0111000);
        q.push_back(7'b0000001);
        repeat (e_ta - 1) q.push_back(7'b0000000);
      end
    end
  end

  // ---------------- stimulus
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    int a, b;
    s_cmp = 0; s_bad = 0; done = 0; live = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    e_rd   = (span(T_CYC) > span(T_OEA)) ? span(T_CYC) : span(T_OEA);
    e_we   = span(T_WP);
    if (span(T_ASU) > e_we) e_we = span(T_ASU);
    if (span(T_DSU) > e_we) e_we = span(T_DSU);
    e_wrec = (span(T_CYC) > e_we) ? span(T_CYC) - e_we : 0;
    e_ta   = span(T_REL);
    @(negedge clk);
    chk(!rst_n && ce1_n && !ce2 && oe_n && we_n && !dq_oe && !rd_valid && req_ready,
        "R1 reset pins", {ce1_n, ce2, oe_n, we_n, dq_oe, rd_valid, req_ready}, 7'b1011001, s_cmp, s_bad);
    @(posedge rst_n);
    live = 1;
    // R2: held requests queue up back to back behind busy sequences
    issue(1'b1, 17'h00000, 8'hA5);
    issue(1'b1, 17'h1FFFF, 8'h3C);
    issue(1'b1, 17'h00005, 8'h11);
    issue(1'b1, 17'h00005, 8'h22);
    issue(1'b0, 17'h00005, 8'h00);
    issue(1'b0, 17'h1FFFF, 8'h00);
    issue(1'b0, 17'h00000, 8'h00);
    issue(1'b0, 17'h00009, 8'h00);
    repeat (3) @(posedge clk);
    for (int i = 0; i < 12; i++) begin
      a = (i * 7919 + 13) % 131072;
      b = (i * 29 + 7) % 256;
      issue(1'b1, AW'(a), DW'(b));
      if (i % 3 == 0) repeat (2) @(posedge clk);
      issue(1'b0, AW'(a), 8'h00);
    end
    for (int i = 0; i < 4; i++) issue(1'b0, AW'((i * 7919 + 13) % 131072), 8'h00);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0 && req_ready, "R2 sequence complete", q.size(), 0, s_cmp, s_bad);
    done = 1;
  end

endmodule

// File: tb/test_sram_timing_ctrl.sv
`timescale 1ns/1ps
module test_sram_timing_ctrl;

  localparam int CLK_NS = 10;

  logic clk, rst_n;
  int   c55, b55, c70, b70;
  logic d55, d70;

  initial begin
    clk = 1'b0;
    forever #(CLK_NS / 2) clk = ~clk;
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  sram_tc_harness #(.GRADE_NS(55), .CLK_NS(CLK_NS)) u_fast (
    .clk(clk), .rst_n(rst_n), .n_cmp(c55), .n_bad(b55), .done(d55));

  sram_tc_harness #(.GRADE_NS(70), .CLK_NS(CLK_NS)) u_slow (
    .clk(clk), .rst_n(rst_n), .n_cmp(c70), .n_bad(b70), .done(d70));

  initial begin
    int total, bad;
    for (int c = 0; c < 100000 && !(d55 === 1'b1 && d70 === 1'b1); c++) @(posedge clk);
    #1;
    total = c55 + c70;
    bad   = b55 + b70;
    if (!(d55 === 1'b1 && d70 === 1'b1)) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: got done %0b%0b expected 11", d55, d70);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule